// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs processor-side bus transactions, one at a time, on a 20-bit bus that carries address and status on shared lines and has an 8-bit data path. Every transaction moves through four clock states, T1 to T4. Wait states (Tw) are added after T3 for as long as the addressed target holds READY low. Between transactions the sequencer rests in idle states (Ti), and no cycle is active in those states.

During T1 the block raises ALE and puts the full address on the bus. An I/O cycle drives the four top lines to zero. From T2 to the end of the cycle, the top four lines carry a status nibble instead: a constant zero, the interrupt-enable flag, and the two-bit segment code. The low eight lines carry write data on write cycles. A 3-bit cycle code names the kind of transaction. The code is valid from T1 through the last T3/Tw state, and it returns to the passive value in T4 and in Ti.

The requester holds a request until it sees ALE, and then it may present the next request. A request that arrives in T4 starts its T1 on the following clock, so no idle state sits between the two cycles.

Top module: `busSeqTop`

## Requirements
- R1: Each transaction goes through T1, T2, T3, then zero or more Tw, then T4. ALE is high only in T1 and for exactly one cycle. `done` is high only in T4, exactly 3+n cycles after the ALE cycle, where n is the number of wait states.
- R2: `busReady` is sampled at the clock edge that ends T3 and at the edge that ends each Tw. A low sample adds one Tw. The first high sample moves the cycle to T4.
- R3: In T1, `adBus` carries the request address. For the I/O kinds (code 001 = I/O read, 010 = I/O write), bits 19:16 are forced to zero and bits 15:0 hold the port address.
- R4: From T2 through T4, `adBus[19]`=0, `adBus[18]`=interrupt-enable flag, and `adBus[17:16]`=segment code (00 extra, 01 stack, 10 code/none, 11 data). `adBus[15:8]` keeps the address bits during these states.
- R5: From T2 through T4, `adBus[7:0]` carries the write data for the write kinds (010 I/O write, 110 memory write). For all other kinds these bits are zero.
- R6: `statusOut` equals the cycle code from T1 through the last T3/Tw state. It is 111 (passive) in T4, in Ti and during reset. The codes are: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 fetch, 101 memory read, 110 memory write.
- R7: For the read kinds (000, 001, 100, 101), `rdData` takes `dataIn` at the edge that ends the last T3/Tw state. The value is shown in T4 and held until the next read capture. Other kinds leave `rdData` unchanged.
- R8: A request seen in Ti or T4 is accepted at that clock edge, and T1 follows on the next cycle. A request seen in T4 therefore gives back-to-back cycles with no Ti between them. When no request is present, T4 is followed by Ti.
- R9: A request with code 111 is ignored. The sequencer stays in Ti, ALE stays low and `statusOut` stays 111.
- R10: During reset and afterwards with no request, ALE=0, `done`=0, `statusOut`=111, `adBus`=0 and `rdData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present; held until ALE is seen |
| reqKind | input | 3 | Cycle code of the request |
| reqAddr | input | 20 | Memory address or I/O port address |
| reqSeg | input | 2 | Segment code for the status nibble |
| reqIntEn | input | 1 | Interrupt-enable flag for the status nibble |
| reqWrData | input | 8 | Write data |
| busReady | input | 1 | Target ready, sampled at the end of T3/Tw |
| dataIn | input | 8 | Read data from the target |
| adBus | output | 20 | Multiplexed address/status/data lines |
| ale | output | 1 | Address latch enable, high in T1 |
| statusOut | output | 3 | Cycle code, 111 when passive |
| rdData | output | 8 | Last captured read data |
| done | output | 1 | One-cycle pulse in T4 |

## Verification
The assertions assume three things about the inputs. A request stays stable from the cycle it is presented until ALE answers it. `busReady` and `dataIn` are settled before the edge that samples them. Reset lasts at least one clock. The driver changes request fields only at a falling edge, and only after it has observed ALE for the request it was holding. The monitor sets `busReady` and `dataIn` at the falling edge before each sampling edge, and it counts the states since ALE to decide when READY should rise. Through the scoreboard, the bench covers wait counts of zero to five, I/O addresses whose upper bits are set, back-to-back cycles and a passive request.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  localparam int STAT_W = 4;

  localparam logic [2:0] CY_INTA    = 3'b000;
  localparam logic [2:0] CY_IORD    = 3'b001;
  localparam logic [2:0] CY_IOWR    = 3'b010;
  localparam logic [2:0] CY_HALT    = 3'b011;
  localparam logic [2:0] CY_FETCH   = 3'b100;
  localparam logic [2:0] CY_MEMRD   = 3'b101;
  localparam logic [2:0] CY_MEMWR   = 3'b110;
  localparam logic [2:0] CY_PASSIVE = 3'b111;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef struct packed {
    logic   loadReq;
    logic   endData;
    phase_e phase;
  } strobe_t;

  function automatic logic kindIsIo(input logic [2:0] k);
    return (k == CY_IORD) || (k == CY_IOWR);
  endfunction

  function automatic logic kindIsWrite(input logic [2:0] k);
    return (k == CY_IOWR) || (k == CY_MEMWR);
  endfunction

  function automatic logic kindIsRead(input logic [2:0] k);
    return (k == CY_INTA) || (k == CY_IORD) || (k == CY_FETCH) || (k == CY_MEMRD);
  endfunction

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic [2:0] reqKind,
  input  logic    busReady,
  output strobe_t strobes,
  output logic    ale,
  output logic    done
);

  phase_e phase, phaseNext;
  logic   acceptNow;
  logic   slotOpen;

  assign slotOpen  = (phase == PH_IDLE) || (phase == PH_T4);
  assign acceptNow = slotOpen && reqValid && (reqKind != CY_PASSIVE);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: phaseNext = acceptNow ? PH_T1 : PH_IDLE;
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = PH_T3;
      PH_T3:   phaseNext = busReady ? PH_T4 : PH_TW;
      PH_TW:   phaseNext = busReady ? PH_T4 : PH_TW;
      PH_T4:   phaseNext = acceptNow ? PH_T1 : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobes.loadReq = acceptNow;
    strobes.endData = ((phase == PH_T3) || (phase == PH_TW)) && busReady;
    strobes.phase   = phase;
  end

  assign ale  = (phase == PH_T1);
  assign done = (phase == PH_T4);

  // R1: latch enable is a single-cycle pulse
  p_ale_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R1: completion only follows a data state
  p_done_origin_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(phase) == PH_T3 || $past(phase) == PH_TW));

  // R2: a wait state is only entered from T3 or another wait state while not ready
  p_wait_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TW) |-> (($past(phase) == PH_T3 || $past(phase) == PH_TW) && !$past(busReady)));

  // R2: ready at the end of T3/Tw leads straight to T4
  p_ready_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_T3 || phase == PH_TW) && busReady) |=> done);

  // R8: an accepted request starts T1 on the next clock
  p_accept_t1_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slotOpen && reqValid && reqKind != CY_PASSIVE) |=> ale);

  // R9: a passive request in idle leaves the sequencer idle
  p_passive_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && (!reqValid || reqKind == CY_PASSIVE)) |=> !ale);

endmodule

// File: rtl/busSeqPath.sv
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int IO_ADDR_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSeg,
  input  logic              reqIntEn,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] adBus,
  output logic [2:0]        statusOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int MID_W   = ADDR_W - STAT_W - DATA_W;
  localparam int LOW_TOP = ADDR_W - STAT_W;

  logic [ADDR_W-1:0] curAddr;
  logic [2:0]        curKind;
  logic [1:0]        curSeg;
  logic              curIe;
  logic [DATA_W-1:0] curWr;
  logic [ADDR_W-1:0] t1Addr;
  logic [STAT_W-1:0] statNibble;
  logic [DATA_W-1:0] lowLanes;
  logic              inCycle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curKind <= CY_PASSIVE;
      curSeg  <= '0;
      curIe   <= 1'b0;
      curWr   <= '0;
    end else if (strobes.loadReq) begin
      curAddr <= reqAddr;
      curKind <= reqKind;
      curSeg  <= reqSeg;
      curIe   <= reqIntEn;
      curWr   <= reqWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strobes.endData && kindIsRead(curKind))
      rdData <= dataIn;
  end

  generate
    if (IO_ADDR_W < ADDR_W) begin : g_ioMask
      always_comb begin
        t1Addr = curAddr;
        if (kindIsIo(curKind))
          t1Addr = {{(ADDR_W-IO_ADDR_W){1'b0}}, curAddr[IO_ADDR_W-1:0]};
      end
    end else begin : g_ioFull
      assign t1Addr = curAddr;
    end
  endgenerate

  assign statNibble = {1'b0, curIe, curSeg};
  assign lowLanes   = kindIsWrite(curKind) ? curWr : '0;
  assign inCycle    = (strobes.phase == PH_T1) || (strobes.phase == PH_T2) ||
                      (strobes.phase == PH_T3) || (strobes.phase == PH_TW);

  always_comb begin
    unique case (strobes.phase)
      PH_IDLE: adBus = '0;
      PH_T1:   adBus = t1Addr;
      default: adBus = {statNibble, curAddr[LOW_TOP-1:DATA_W], lowLanes};
    endcase
  end

  assign statusOut = inCycle ? curKind : CY_PASSIVE;

  // R4: the top line after T1 is the constant-zero status bit
  p_s6_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phase == PH_T1) |=> !adBus[ADDR_W-1]);

  // R4: middle address lines stay put from T1 into T2
  p_mid_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phase == PH_T1) |=> $stable(adBus[LOW_TOP-1:DATA_W]));

  // R6: the cycle code stays constant from T1 until T4
  p_code_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phase == PH_T2 || strobes.phase == PH_T3 || strobes.phase == PH_TW)
      |-> $stable(statusOut));

  // R6: cycle code is passive in T4
  p_t4_passive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.phase == PH_T4) |-> (statusOut == CY_PASSIVE));

  // R7: read data only moves at the end of a data state
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.endData |=> $stable(rdData));

  if (MID_W < 0) begin : g_badWidth
    initial $error("address width too small for status and data lanes");
  end

endmodule

// File: rtl/busSeqTop.sv
module busSeqTop
  import busSeqPkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int IO_ADDR_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSeg,
  input  logic              reqIntEn,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              busReady,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] adBus,
  output logic              ale,
  output logic [2:0]        statusOut,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  strobe_t strobes;

  busSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .busReady (busReady),
    .strobes  (strobes),
    .ale      (ale),
    .done     (done)
  );

  busSeqPath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IO_ADDR_W (IO_ADDR_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqKind   (reqKind),
    .reqAddr   (reqAddr),
    .reqSeg    (reqSeg),
    .reqIntEn  (reqIntEn),
    .reqWrData (reqWrData),
    .dataIn    (dataIn),
    .adBus     (adBus),
    .statusOut (statusOut),
    .rdData    (rdData)
  );

  // R10: nothing is driven while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && statusOut == 3'b111 && !done) |-> (adBus == '0 || !$stable(statusOut) || $past(done) || $past(statusOut) != 3'b111 || $past(ale)));

endmodule

// File: tb/tb_busSeqTop.sv
module tb_busSeqTop;

  typedef struct {
    logic [19:0] addr;
    logic [2:0]  kind;
    logic [1:0]  seg;
    logic        ie;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    int          waits;
  } txn_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'b111;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqSeg = '0;
  logic        reqIntEn = 1'b0;
  logic [7:0]  reqWrData = '0;
  logic        busReady = 1'b1;
  logic [7:0]  dataIn = '0;
  logic [19:0] adBus;
  logic        ale;
  logic [2:0]  statusOut;
  logic [7:0]  rdData;
  logic        done;

  int checks = 0;
  int fails = 0;
  txn_t expQ[$];
  bit monActive = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  busSeqTop dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqSeg(reqSeg), .reqIntEn(reqIntEn),
    .reqWrData(reqWrData), .busReady(busReady), .dataIn(dataIn),
    .adBus(adBus), .ale(ale), .statusOut(statusOut), .rdData(rdData),
    .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isIo(input logic [2:0] k);
    return (k == 3'b001) || (k == 3'b010);
  endfunction
  function automatic bit isWr(input logic [2:0] k);
    return (k == 3'b010) || (k == 3'b110);
  endfunction
  function automatic bit isRd(input logic [2:0] k);
    return (k == 3'b000) || (k == 3'b001) || (k == 3'b100) || (k == 3'b101);
  endfunction

  // driver: push expectation, present request, hold it until ALE answers
  task automatic send(input logic [2:0] kind, input logic [19:0] addr,
                      input logic [1:0] seg, input logic ie,
                      input logic [7:0] wd, input logic [7:0] rd, input int waits);
    txn_t t;
    t.addr = addr; t.kind = kind; t.seg = seg; t.ie = ie;
    t.wdata = wd; t.rdata = rd; t.waits = waits;
    expQ.push_back(t);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqSeg = seg;
    reqIntEn = ie; reqWrData = wd;
    do @(negedge clk); while (!ale);
  endtask

  task automatic release_req();
    reqValid = 1'b0;
    reqKind = 3'b111;
  endtask

  task automatic drain();
    while (expQ.size() != 0 || monActive) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    txn_t cur;
    int k = 0;
    logic [7:0] lastRd = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (ale) begin
          if (expQ.size() == 0) begin
            check("R8 unexpected ALE", 32'd1, 32'd0);
            monActive = 0;
          end else begin
            cur = expQ.pop_front();
            k = 0;
            monActive = 1;
          end
        end else if (monActive) begin
          k++;
        end

        if (monActive) begin
          if (k == 0) begin
            check("R3 T1 address", adBus,
                  isIo(cur.kind) ? {4'h0, cur.addr[15:0]} : cur.addr);
            check("R6 code in T1", statusOut, cur.kind);
          end else begin
            check("R4 status nibble", adBus[19:16], {1'b0, cur.ie, cur.seg});
            check("R4 mid address", adBus[15:8], cur.addr[15:8]);
            check("R5 low lanes", adBus[7:0], isWr(cur.kind) ? cur.wdata : 8'h00);
            if (k < 3 + cur.waits) begin
              check("R1 no early done", done, 1'b0);
              check("R6 code in T2-Tw", statusOut, cur.kind);
              check("R1 no ALE mid-cycle", ale, 1'b0);
            end else begin
              check("R1 R2 done after waits", done, 1'b1);
              check("R6 passive in T4", statusOut, 3'b111);
              if (isRd(cur.kind)) lastRd = cur.rdata;
              check("R7 read data", rdData, lastRd);
            end
          end
          busReady = (k >= 2 + cur.waits);
          dataIn   = (k >= 2 + cur.waits) ? cur.rdata : ~cur.rdata;
          if (k == 3 + cur.waits) monActive = 0;
        end else begin
          busReady = 1'b1;
          if (done) check("R1 stray done", done, 1'b0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 ale in reset", ale, 1'b0);
    check("R10 status in reset", statusOut, 3'b111);
    check("R10 done in reset", done, 1'b0);
    check("R10 bus in reset", adBus, 20'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 idle bus", adBus, 20'h0);
    check("R10 idle rdData", rdData, 8'h00);
    check("R10 idle status", statusOut, 3'b111);

    // single cycles with idle gaps
    send(3'b101, 20'hABCDE, 2'b11, 1'b1, 8'h00, 8'h5A, 0);
    release_req(); drain();
    send(3'b110, 20'h12345, 2'b00, 1'b0, 8'hC3, 8'h11, 2);
    release_req(); drain();
    // R3: I/O read with upper bits set must show zeros there
    send(3'b001, 20'hF8421, 2'b01, 1'b1, 8'h00, 8'hA7, 1);
    release_req(); drain();
    send(3'b010, 20'h9FFFF, 2'b10, 1'b0, 8'h3C, 8'h00, 0);
    release_req(); drain();

    // R8: back-to-back cycles, no Ti between them
    send(3'b100, 20'hFFFF0, 2'b10, 1'b0, 8'h00, 8'hEA, 5);
    send(3'b000, 20'h00000, 2'b10, 1'b1, 8'h00, 8'h08, 0);
    send(3'b011, 20'h00123, 2'b10, 1'b1, 8'h00, 8'h99, 0);
    send(3'b110, 20'h54321, 2'b11, 1'b1, 8'h7E, 8'h00, 3);
    send(3'b101, 20'h0BEEF, 2'b01, 1'b0, 8'h00, 8'h61, 0);
    release_req(); drain();

    // R9: a passive request is ignored
    reqValid = 1'b1; reqKind = 3'b111; reqAddr = 20'h77777;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 passive ignored ALE", ale, 1'b0);
      check("R9 passive ignored status", statusOut, 3'b111);
    end
    release_req();
    @(negedge clk);
    check("R7 rdData held after write/passive", rdData, 8'h61);

    send(3'b001, 20'h000FF, 2'b00, 1'b0, 8'h00, 8'h42, 4);
    release_req(); drain();
    check("R8 idle after last cycle", ale, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule